// File: doc/BRIEF.md
# Memory bus and cell test sequencer

This block is a built-in self-test engine for a synchronous single-port RAM. After a one-cycle `start` pulse it drives the memory through three phases, always in the same order. The first phase checks each data line on its own at address 0. The second checks each address line on its own, using only offset 0 and the power-of-two offsets. The third writes and reads back every cell with a fixed pattern and then with its bitwise inverse. The test overwrites the whole array, so it may only be started when the array holds nothing that is still needed.

The memory side is a valid/ready request channel with a write-enable, an address and write data. The engine raises `mem_req_valid` and keeps the request and its payload unchanged until `mem_req_ready` is sampled high. A request is accepted on the clock edge where both are high. The memory can stall the engine for any number of cycles by holding `mem_req_ready` low. Read data must be valid on `mem_rdata` in the cycle after the read is accepted. The engine issues nothing in that cycle while it compares. The first miscompare stops the run and freezes a report of the phase, the address, the expected word and the word read. A run with no miscompare ends with `done` high and `fail` low.

Top module: `mem_bist_seq`

## Requirements
- R1: During and right after reset, `busy`, `done`, `fail` and `mem_req_valid` are all low.
- R2: A `start` pulse while the engine is not busy begins a run: `busy` is high in the next cycle. A `start` while busy has no effect on the request sequence.
- R3: A request whose `mem_req_ready` is low stays valid with the same write-enable, address and data in the next cycle. In the cycle after a read is accepted, `mem_req_valid` is low.
- R4: Data phase (phase code 1): at address 0, for bit k = 0 up to DW-1, write the word with only bit k set and read it back expecting that word. Then repeat for k = 0 up to DW-1 with the word that has only bit k clear.
- R5: Address phase (phase code 2): the marker word M has every odd-numbered bit set and every even-numbered bit clear. First write M to offsets 0, 1, 2, 4, … up to 2^(AW-1), in that order. Then, for i = 0 up to AW-1: write ~M at 2^i; read all marked offsets in ascending order, expecting ~M at 2^i and M at every other offset; then write M back at 2^i.
- R6: Device phase (phase code 3): write the cell pattern P (default equal to M) to every address from 0 up to 2^AW-1, then read them all in ascending order. Then do the same with ~P.
- R7: On the first read whose data differs from the expected word, the engine issues no further request. It sets `done` and `fail`, and it reports the phase code, the address, the expected word and the read word on the `fail_*` ports.
- R8: If every read matches, the engine ends after the last device-phase read with `done` high, `fail` low and all `fail_*` fields zero.
- R9: `done` and the report hold until the next `start`. A `start` while `done` is high clears `done` and begins a new run.
- R10: A miscompare on the final read of a phase is reported with that phase's code, not the code of the phase that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that starts a run |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, holds until next start |
| fail | output | 1 | Run stopped on a miscompare |
| fail_phase | output | 2 | Phase code of the miscompare (1 data, 2 address, 3 device) |
| fail_addr | output | AW | Address of the failing read |
| fail_exp | output | DW | Word the failing read should have returned |
| fail_got | output | DW | Word the failing read returned |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after a read is accepted |

## Verification
The compare of the final read of a phase happens in the same cycle as the step generator's move into the next phase. At the end of the device phase it also coincides with the end of the run. The bench provokes this with a one-shot corruption of exactly the last data-phase read, and in another run of exactly the last device-phase read. Each result is judged by requiring the reported phase code, address, expected word and read word to match the bench's own prediction, and by requiring that no request follows the failure.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  // Phase codes; the values are visible on fail_phase.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_ADDR = 2'd2,
    PH_CELL = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_END   = 2'd3
  } xfer_st_e;

endpackage

// File: rtl/mbist_stepper.sv
// Generates the ordered list of memory operations for the three phases.
// The current operation is presented combinationally; adv moves to the next.
module mbist_stepper
  import mbist_pkg::*;
#(
  parameter int          AW       = 10,
  parameter int          DW       = 16,
  parameter logic [DW-1:0] CELL_PAT = {(DW/2){2'b10}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  output phase_e        phase,
  output logic          op_we,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic          op_last
);

  localparam int DEPTH = 1 << AW;
  localparam int DBITS = $clog2(2 * DW);
  localparam int CW    = ((AW + 1) > (DBITS + 1)) ? (AW + 1) : (DBITS + 1);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] a_q, a_d;   // outer index: bit step / probed line / pass
  logic [CW-1:0] b_q, b_d;   // inner index: marked offset / cell address
  logic [1:0]    sub_q, sub_d;

  // Alternating marker: odd bits set.
  logic [DW-1:0] marker;
  for (genvar i = 0; i < DW; i++) begin : g_mark
    assign marker[i] = ((i % 2) == 1);
  end

  // Marked offset j: 0 for j = 0, else 2^(j-1).
  function automatic logic [AW-1:0] loc_of(input logic [CW-1:0] j);
    if (j == '0) return '0;
    return AW'(1) << (j - CW'(1));
  endfunction

  logic [CW-1:0] bitpos;
  logic [DW-1:0] walk;
  logic          walk_ones;

  assign walk_ones = (a_q < CW'(DW));
  assign bitpos    = walk_ones ? a_q : (a_q - CW'(DW));
  assign walk      = DW'(1) << bitpos;

  // Current operation
  always_comb begin
    op_we   = 1'b0;
    op_addr = '0;
    op_data = '0;
    case (ph_q)
      PH_DATA: begin
        op_we   = (sub_q == 2'd0);
        op_data = walk_ones ? walk : ~walk;
      end
      PH_ADDR: begin
        case (sub_q)
          2'd0: begin
            op_we   = 1'b1;
            op_addr = loc_of(b_q);
            op_data = marker;
          end
          2'd1: begin
            op_we   = 1'b1;
            op_addr = loc_of(a_q);
            op_data = ~marker;
          end
          2'd2: begin
            op_we   = 1'b0;
            op_addr = loc_of(b_q);
            op_data = (b_q == a_q) ? ~marker : marker;
          end
          default: begin
            op_we   = 1'b1;
            op_addr = loc_of(a_q);
            op_data = marker;
          end
        endcase
      end
      PH_CELL: begin
        op_we   = (sub_q == 2'd0);
        op_addr = b_q[AW-1:0];
        op_data = a_q[0] ? ~CELL_PAT : CELL_PAT;
      end
      default: ;
    endcase
  end

  assign op_last = (ph_q == PH_CELL) && (a_q == CW'(1)) && (sub_q == 2'd1) &&
                   (b_q == CW'(DEPTH - 1));

  // Advance
  always_comb begin
    ph_d  = ph_q;
    a_d   = a_q;
    b_d   = b_q;
    sub_d = sub_q;
    if (load) begin
      ph_d  = PH_DATA;
      a_d   = '0;
      b_d   = '0;
      sub_d = 2'd0;
    end else if (adv) begin
      case (ph_q)
        PH_DATA: begin
          if (sub_q == 2'd0) begin
            sub_d = 2'd1;
          end else if (a_q == CW'(2 * DW - 1)) begin
            ph_d  = PH_ADDR;
            a_d   = '0;
            b_d   = '0;
            sub_d = 2'd0;
          end else begin
            a_d   = a_q + CW'(1);
            sub_d = 2'd0;
          end
        end
        PH_ADDR: begin
          case (sub_q)
            2'd0: begin
              if (b_q == CW'(AW)) begin
                sub_d = 2'd1;
                a_d   = CW'(1);
                b_d   = '0;
              end else begin
                b_d = b_q + CW'(1);
              end
            end
            2'd1: begin
              sub_d = 2'd2;
              b_d   = '0;
            end
            2'd2: begin
              if (b_q == CW'(AW)) sub_d = 2'd3;
              else                b_d   = b_q + CW'(1);
            end
            default: begin
              if (a_q == CW'(AW)) begin
                ph_d  = PH_CELL;
                a_d   = '0;
                b_d   = '0;
                sub_d = 2'd0;
              end else begin
                a_d   = a_q + CW'(1);
                sub_d = 2'd1;
              end
            end
          endcase
        end
        PH_CELL: begin
          if (b_q != CW'(DEPTH - 1)) begin
            b_d = b_q + CW'(1);
          end else if (sub_q == 2'd0) begin
            sub_d = 2'd1;
            b_d   = '0;
          end else if (a_q == '0) begin
            a_d   = CW'(1);
            sub_d = 2'd0;
            b_d   = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      a_q   <= '0;
      b_q   <= '0;
      sub_q <= 2'd0;
    end else begin
      ph_q  <= ph_d;
      a_q   <= a_d;
      b_q   <= b_d;
      sub_q <= sub_d;
    end
  end

  assign phase = ph_q;

endmodule

// File: rtl/mbist_xfer.sv
// Drives the valid/ready request channel and compares read data one cycle
// after each accepted read.
module mbist_xfer
  import mbist_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_we,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_data,
  input  logic          op_last,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_we,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] rdata,
  output logic          load,
  output logic          adv,
  output logic          miss,
  output logic          finish,
  output logic          busy
);

  xfer_st_e st_q, st_d;
  logic     accept;
  logic     match;

  assign req_valid = (st_q == ST_ISSUE);
  assign req_we    = op_we;
  assign req_addr  = op_addr;
  assign req_wdata = op_data;
  assign accept    = req_valid && req_ready;
  assign match     = (rdata == op_data);

  assign load   = ((st_q == ST_IDLE) || (st_q == ST_END)) && start;
  assign adv    = (accept && op_we) || ((st_q == ST_WAIT) && match);
  assign miss   = (st_q == ST_WAIT) && !match;
  assign finish = adv && op_last;
  assign busy   = (st_q == ST_ISSUE) || (st_q == ST_WAIT);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE, ST_END: if (start) st_d = ST_ISSUE;
      ST_ISSUE: begin
        if (accept && !op_we) st_d = ST_WAIT;
        else if (finish)      st_d = ST_END;
      end
      ST_WAIT: begin
        if (miss || finish) st_d = ST_END;
        else                st_d = ST_ISSUE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/mbist_result.sv
// Holds the completion flags and the first-miscompare report.
module mbist_result
  import mbist_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          miss,
  input  logic          finish,
  input  phase_e        phase,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] exp_word,
  input  logic [DW-1:0] got_word,
  output logic          done,
  output logic          fail,
  output logic [1:0]    f_phase,
  output logic [AW-1:0] f_addr,
  output logic [DW-1:0] f_exp,
  output logic [DW-1:0] f_got
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      fail    <= 1'b0;
      f_phase <= '0;
      f_addr  <= '0;
      f_exp   <= '0;
      f_got   <= '0;
    end else if (load) begin
      done    <= 1'b0;
      fail    <= 1'b0;
      f_phase <= '0;
      f_addr  <= '0;
      f_exp   <= '0;
      f_got   <= '0;
    end else if (miss) begin
      done    <= 1'b1;
      fail    <= 1'b1;
      f_phase <= phase;
      f_addr  <= addr;
      f_exp   <= exp_word;
      f_got   <= got_word;
    end else if (finish) begin
      done    <= 1'b1;
    end
  end

endmodule

// File: rtl/mem_bist_seq.sv
module mem_bist_seq
  import mbist_pkg::*;
#(
  parameter int            AW       = 10,
  parameter int            DW       = 16,
  parameter logic [DW-1:0] CELL_PAT = {(DW/2){2'b10}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [1:0]    fail_phase,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] fail_exp,
  output logic [DW-1:0] fail_got,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic [DW-1:0] mem_rdata
);

  phase_e        phase;
  logic          op_we, op_last;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic          load, adv, miss, finish;

  mbist_stepper #(.AW(AW), .DW(DW), .CELL_PAT(CELL_PAT)) u_stepper (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .adv     (adv),
    .phase   (phase),
    .op_we   (op_we),
    .op_addr (op_addr),
    .op_data (op_data),
    .op_last (op_last)
  );

  mbist_xfer #(.AW(AW), .DW(DW)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_we     (op_we),
    .op_addr   (op_addr),
    .op_data   (op_data),
    .op_last   (op_last),
    .req_valid (mem_req_valid),
    .req_ready (mem_req_ready),
    .req_we    (mem_req_we),
    .req_addr  (mem_req_addr),
    .req_wdata (mem_req_wdata),
    .rdata     (mem_rdata),
    .load      (load),
    .adv       (adv),
    .miss      (miss),
    .finish    (finish),
    .busy      (busy)
  );

  mbist_result #(.AW(AW), .DW(DW)) u_result (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .miss     (miss),
    .finish   (finish),
    .phase    (phase),
    .addr     (op_addr),
    .exp_word (op_data),
    .got_word (mem_rdata),
    .done     (done),
    .fail     (fail),
    .f_phase  (fail_phase),
    .f_addr   (fail_addr),
    .f_exp    (fail_exp),
    .f_got    (fail_got)
  );

endmodule

// File: rtl/mbist_seq_chk.sv
module mbist_seq_chk #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic [1:0]    fail_phase,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic [AW-1:0] mem_req_addr,
  input logic [DW-1:0] mem_req_wdata
);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_we) &&
      $stable(mem_req_addr) && $stable(mem_req_wdata));

  // R3
  rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready && !mem_req_we |=> !mem_req_valid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);

  // R2
  start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy);

  // R7
  fail_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done && (fail_phase != 2'd0));

  // R8
  pass_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fail |-> fail_phase == 2'd0);

  // R9
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(fail) && $stable(fail_phase));

endmodule

bind mem_bist_seq mbist_seq_chk #(.AW(AW), .DW(DW)) u_seq_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .busy          (busy),
  .done          (done),
  .fail          (fail),
  .fail_phase    (fail_phase),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata)
);

// File: tb/mem_bist_seq_bench.sv
`timescale 1ns/1ps
module mem_bist_seq_bench;

  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int NREAD = 2 * DW + AW * (AW + 1) + 2 * DEPTH;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, start;
  logic          busy, done, fail;
  logic [1:0]    fail_phase;
  logic [AW-1:0] fail_addr;
  logic [DW-1:0] fail_exp, fail_got;
  logic          mem_req_valid, mem_req_ready, mem_req_we;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic [DW-1:0] mem_rdata = '0;

  mem_bist_seq #(.AW(AW), .DW(DW)) u_mem_bist_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .fail(fail),
    .fail_phase(fail_phase), .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_got(fail_got),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata), .mem_rdata(mem_rdata)
  );

  int errors = 0;
  int checks = 0;

  typedef struct { bit we; int addr; logic [DW-1:0] d; int ph; } op_t;
  op_t q[$];

  // Fault modes: 0 none, 1 data bit stuck at 1, 2 address line stuck at 0,
  // 3 one-shot flip of bit 0 on the fault_n-th read.
  int   fmode = 0, fbit = 0, fault_n = 0;
  bit   bp_en = 0, clr = 0, mon_en = 0;
  logic [7:0] lf = 8'h5A;
  logic [DW-1:0] mem [DEPTH];
  int   rd_cnt = 0;

  bit          exp_fail;
  int          exp_ph, exp_addr;
  logic [DW-1:0] exp_e, exp_g;

  function automatic int eff(int a);
    if (fmode == 2) return a & ~(1 << fbit);
    return a;
  endfunction

  function automatic logic [DW-1:0] faulty(logic [DW-1:0] v, int rc);
    logic [DW-1:0] r;
    r = v;
    if (fmode == 1) r = r | (DW'(1) << fbit);
    if (fmode == 3 && rc == fault_n) r = r ^ DW'(1);
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Memory model with back-pressure and fault injection
  assign mem_req_ready = bp_en ? lf[0] : 1'b1;

  always @(posedge clk) begin
    lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    if (clr) begin
      rd_cnt <= 0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) mem[eff(int'(mem_req_addr))] <= mem_req_wdata;
      else begin
        mem_rdata <= faulty(mem[eff(int'(mem_req_addr))], rd_cnt + 1);
        rd_cnt    <= rd_cnt + 1;
      end
    end
  end

  task automatic push(bit we, int a, logic [DW-1:0] d, int ph);
    op_t o;
    o.we = we; o.addr = a; o.d = d; o.ph = ph;
    q.push_back(o);
  endtask

  function automatic int loc(int j);
    return (j == 0) ? 0 : (1 << (j - 1));
  endfunction

  // Reference op list from R4..R6, then prediction of the first miscompare
  task automatic build();
    logic [DW-1:0] mk, w, v, got;
    logic [DW-1:0] m [DEPTH];
    int rc;
    q.delete();
    for (int i = 0; i < DW; i++) mk[i] = (i % 2 == 1);
    for (int k = 0; k < 2 * DW; k++) begin
      w = (k < DW) ? (DW'(1) << k) : ~(DW'(1) << (k - DW));
      push(1, 0, w, 1);
      push(0, 0, w, 1);
    end
    for (int j = 0; j <= AW; j++) push(1, loc(j), mk, 2);
    for (int t = 1; t <= AW; t++) begin
      push(1, loc(t), ~mk, 2);
      for (int j = 0; j <= AW; j++) push(0, loc(j), (j == t) ? ~mk : mk, 2);
      push(1, loc(t), mk, 2);
    end
    for (int p = 0; p < 2; p++) begin
      v = p ? ~mk : mk;
      for (int a = 0; a < DEPTH; a++) push(1, a, v, 3);
      for (int a = 0; a < DEPTH; a++) push(0, a, v, 3);
    end
    for (int a = 0; a < DEPTH; a++) m[a] = '0;
    rc = 0;
    exp_fail = 0; exp_ph = 0; exp_addr = 0; exp_e = '0; exp_g = '0;
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].we) m[eff(q[i].addr)] = q[i].d;
      else begin
        rc++;
        got = faulty(m[eff(q[i].addr)], rc);
        if (got !== q[i].d) begin
          exp_fail = 1; exp_ph = q[i].ph; exp_addr = q[i].addr;
          exp_e = q[i].d; exp_g = got;
          q = q[0:i];
          break;
        end
      end
    end
  endtask

  // Per-clock comparison of the request channel against the reference list
  bit            stall_q = 0, rd_q = 0;
  logic          sw;
  logic [AW-1:0] sa;
  logic [DW-1:0] sd;

  always @(negedge clk) begin
    if (!mon_en) begin
      stall_q = 0;
      rd_q    = 0;
    end else begin
      if (stall_q)
        chk(mem_req_valid && mem_req_we == sw && mem_req_addr == sa && mem_req_wdata == sd,
            "R3", "stalled request held", int'({mem_req_valid, mem_req_addr}), int'({1'b1, sa}));
      if (rd_q)
        chk(!mem_req_valid, "R3", "no request in read compare cycle", int'(mem_req_valid), 0);
      if (mem_req_valid && mem_req_ready) begin
        if (q.size() == 0) begin
          chk(0, "R7", "request after expected end", int'(mem_req_addr), 0);
        end else begin
          op_t   o;
          string r;
          o = q.pop_front();
          r = (o.ph == 1) ? "R4" : (o.ph == 2) ? "R5" : "R6";
          chk(mem_req_we == o.we && int'(mem_req_addr) == o.addr && (!o.we || mem_req_wdata == o.d),
              r, "request we/addr/wdata",
              int'({mem_req_we, mem_req_addr, mem_req_wdata}),
              int'({o.we, AW'(o.addr), o.d}));
        end
      end
      stall_q = mem_req_valid && !mem_req_ready;
      rd_q    = mem_req_valid && mem_req_ready && !mem_req_we;
      sw = mem_req_we; sa = mem_req_addr; sd = mem_req_wdata;
    end
  end

  task automatic run(int mode, int fb, int fn, bit bp, bit poke, string ph_req);
    int n;
    logic [1:0] ph_seen;
    fmode = mode; fbit = fb; fault_n = fn; bp_en = bp;
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    build();
    mon_en = 1;
    start  = 1;
    @(negedge clk);
    start  = 0;
    chk(busy && !done, "R2", "busy after start", int'({busy, done}), 2);
    chk(!done, "R9", "start clears done", int'(done), 0);
    if (poke) begin
      repeat (10) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(done, exp_fail ? "R7" : "R8", "done reached", int'(done), 1);
    chk(q.size() == 0, exp_fail ? "R7" : "R8", "all expected requests issued", q.size(), 0);
    chk(fail == exp_fail, exp_fail ? "R7" : "R8", "fail flag", int'(fail), int'(exp_fail));
    if (exp_fail) begin
      chk(int'(fail_phase) == exp_ph, ph_req, "fail phase", int'(fail_phase), exp_ph);
      chk(int'(fail_addr) == exp_addr, "R7", "fail address", int'(fail_addr), exp_addr);
      chk(fail_exp == exp_e, "R7", "expected word", int'(fail_exp), int'(exp_e));
      chk(fail_got == exp_g, "R7", "read word", int'(fail_got), int'(exp_g));
    end else begin
      chk(fail_phase == 0 && fail_addr == 0 && fail_exp == 0 && fail_got == 0,
          "R8", "report fields zero", int'({fail_phase, fail_addr, fail_exp}), 0);
    end
    ph_seen = fail_phase;
    repeat (5) @(negedge clk);
    chk(done && fail == exp_fail && fail_phase == ph_seen && !mem_req_valid,
        "R9", "result held", int'({done, fail, fail_phase}), int'({1'b1, exp_fail, ph_seen}));
    mon_en = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R8 watchdog: actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && !mem_req_valid, "R1", "outputs in reset",
        int'({busy, done, fail, mem_req_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !fail && !mem_req_valid, "R1", "outputs after reset",
        int'({busy, done, fail, mem_req_valid}), 0);

    run(0, 0, 0, 0, 0, "R8");                 // clean memory, no stalls
    run(0, 0, 0, 1, 1, "R8");                 // stalls and a start while busy
    run(1, 3, 0, 1, 0, "R4");                 // data bit 3 stuck at 1
    run(2, 2, 0, 0, 0, "R5");                 // address line 2 stuck at 0
    run(3, 0, 2 * DW, 0, 0, "R10");           // last data-phase read corrupted
    run(3, 0, NREAD, 1, 0, "R10");            // last device-phase read corrupted

    summary();
    $finish;
  end

endmodule